// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

A small 32-bit processor core that runs a subset of a classic three-register load/store instruction set: word load, word store, branch-if-equal, and the register-to-register operations add, subtract, bitwise and, bitwise or and signed set-less-than. Each instruction passes through a chain of one-cycle states. Every instruction has a fetch state and a decode state. It then has an execute state, and, depending on its class, a memory state and a write-back state. The states share one ALU and one memory port. Intermediate values live in an instruction register, two operand registers, an ALU result register and a memory data register.

Control has two levels. A main decoder sorts the opcode into a class and gives a 2-bit ALU operation class. A second stage combines that class with the function field to pick the 4-bit ALU operation. The core has one word-addressed port to an external memory, which holds both program and data. Memory reads are combinational.

Top module: `mcyc_cpu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `mem_addr` is 0 and `mem_we` is 0. Reset clears the program counter and all registers, and puts the sequencer in the fetch state.
- R2: Each fetch reads the word at the program counter and advances the program counter by one word. In the cycle after a fetch, `mem_addr` shows the next word address.
- R3: The ALU operation class is 00 for loads and stores, giving add (code 0010). It is 01 for branches, giving subtract (0110). It is 10 for register operations. With class 10, function field bits [5:0] select the operation: 100000 add (0010), 100010 subtract (0110), 100100 and (0000), 100101 or (0001), 101010 set-less-than (0111). NOR is code 1100.
- R4: A register operation (opcode 000000) writes rs+rt or rs−rt to rd. The instruction fields are rs [25:21], rt [20:16] and rd [15:11].
- R5: Register and/or operations write the bitwise result of rs and rt to rd.
- R6: Set-less-than writes 1 to rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R7: A load (opcode 100011) writes the memory word at byte address rs + sign-extended bits [15:0] into rt. The memory word address is that byte address divided by 4. Negative offsets work.
- R8: A store (opcode 101011) writes rt to the same address as a load would use. `mem_we` is high for exactly one cycle per store and never otherwise.
- R9: A branch (opcode 000100) compares rs and rt. When they are equal, the next fetch comes from (address of the branch + 4) + (sign-extended offset × 4). Otherwise execution continues in sequence. Backward offsets work.
- R10: Register 0 always reads as zero. Writes to it, by a load or by a register operation, have no effect.
- R11: Each state lasts one cycle. Register operations take 4 cycles, loads 5, stores 4 and branches 3, whether or not the branch is taken.
- R12: An unknown opcode, an unknown function code, or a register operation with a nonzero shift field [10:6] leaves registers and memory unchanged. It retires after fetch and decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 32 | Word read from memory at `mem_addr` (combinational) |
| mem_addr | output | 30 | Word address: program counter, or data address in the memory state |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe, one cycle per store |

## Verification
Operand pairs with opposite signs are used for the register operations, so that signed set-less-than differs from an unsigned compare and the and/or results differ from add. A load/store program uses a base register together with a negative offset, which exposes sign-extension and byte-to-word address errors. A branch program contains a taken forward branch that skips over stores, a branch that is not taken, and a backward loop. These show the target arithmetic, and the position of the first store pins down per-class cycle counts. A last program aims loads and register writes at register 0 and inserts unsupported encodings, to confirm that neither changes what later stores write out.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int WORD_W = 32;
  localparam int IMM_W  = 16;
  localparam int FLD_W  = 5;
  localparam int NREG   = 1 << FLD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_RWB, ST_LWB
  } state_t;

  typedef enum logic [1:0] {
    AOP_ADD = 2'b00, AOP_SUB = 2'b01, AOP_FN = 2'b10, AOP_NA = 2'b11
  } aluop_t;

  typedef enum logic [2:0] {
    CL_NONE, CL_RTYPE, CL_LOAD, CL_STORE, CL_BRANCH
  } iclass_t;

  localparam logic [5:0] OPC_RT = 6'b000000;
  localparam logic [5:0] OPC_LD = 6'b100011;
  localparam logic [5:0] OPC_ST = 6'b101011;
  localparam logic [5:0] OPC_BR = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  localparam logic [3:0] AC_AND = 4'b0000;
  localparam logic [3:0] AC_OR  = 4'b0001;
  localparam logic [3:0] AC_ADD = 4'b0010;
  localparam logic [3:0] AC_SUB = 4'b0110;
  localparam logic [3:0] AC_SLT = 4'b0111;
  localparam logic [3:0] AC_NOR = 4'b1100;

  function automatic logic funct_ok(input logic [5:0] fn);
    return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
           (fn == FN_OR)  || (fn == FN_SLT);
  endfunction

  // Main decoder: opcode (plus shift/function screening) to instruction class
  function automatic iclass_t classify(input logic [5:0] op,
                                       input logic [FLD_W-1:0] sh,
                                       input logic [5:0] fn);
    case (op)
      OPC_RT:  return (sh == '0 && funct_ok(fn)) ? CL_RTYPE : CL_NONE;
      OPC_LD:  return CL_LOAD;
      OPC_ST:  return CL_STORE;
      OPC_BR:  return CL_BRANCH;
      default: return CL_NONE;
    endcase
  endfunction

  function automatic aluop_t class_aluop(input iclass_t cl);
    case (cl)
      CL_BRANCH: return AOP_SUB;
      CL_RTYPE:  return AOP_FN;
      default:   return AOP_ADD;
    endcase
  endfunction

  // Second-level control: operation class plus function field to ALU code
  function automatic logic [3:0] alu_ctl(input aluop_t op, input logic [5:0] fn);
    case (op)
      AOP_ADD: return AC_ADD;
      AOP_SUB: return AC_SUB;
      default: begin
        case (fn)
          FN_SUB:  return AC_SUB;
          FN_AND:  return AC_AND;
          FN_OR:   return AC_OR;
          FN_SLT:  return AC_SLT;
          default: return AC_ADD;
        endcase
      end
    endcase
  endfunction

  function automatic word_t alu_calc(input logic [3:0] c, input word_t a, input word_t b);
    case (c)
      AC_AND:  return a & b;
      AC_OR:   return a | b;
      AC_SUB:  return a - b;
      AC_SLT:  return {{(WORD_W-1){1'b0}}, ($signed(a) < $signed(b))};
      AC_NOR:  return ~(a | b);
      default: return a + b;
    endcase
  endfunction

  function automatic word_t sext_imm(input logic [IMM_W-1:0] imm);
    return {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction
endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile
  import mcyc_pkg::*;
#(
  parameter int N_ENT = NREG,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_a,
  input  logic [IDX_W-1:0] ra_b,
  output word_t            rd_a,
  output word_t            rd_b,
  input  logic             we,
  input  logic [IDX_W-1:0] wa,
  input  word_t            wd
);
  word_t regs_q [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) regs_q[i] <= '0;
    end else if (we && wa != '0) begin
      regs_q[wa] <= wd;
    end
  end

  assign rd_a = regs_q[ra_a];
  assign rd_b = regs_q[ra_b];

  // R10: entry zero is never modified
  p_r0_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[0] == '0);
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
  import mcyc_pkg::*;
(
  input  aluop_t      aluop,
  input  logic [5:0]  funct,
  input  word_t       opa,
  input  word_t       opb,
  output logic [3:0]  code,
  output word_t       result,
  output logic        zero
);
  assign code   = alu_ctl(aluop, funct);
  assign result = alu_calc(code, opa, opb);
  assign zero   = (result == '0);

  always_comb begin
    p_memclass_add_r3: assert (aluop != AOP_ADD || code == AC_ADD);
    p_brclass_sub_r3:  assert (aluop != AOP_SUB || code == AC_SUB);
    p_slt_bool_r6:     assert (code != AC_SLT || result[WORD_W-1:1] == '0);
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       ir_op,
  input  logic [FLD_W-1:0] ir_shamt,
  input  logic [5:0]       ir_funct,
  input  logic             alu_zero,
  output state_t           state,
  output iclass_t          cls,
  output aluop_t           aluop,
  output logic             fetch_fire,
  output logic             decode_fire,
  output logic             exec_load,
  output logic             branch_taken,
  output logic             store_fire,
  output logic             mdr_load,
  output logic             reg_write,
  output logic             dst_is_rd,
  output logic             src_is_mem
);
  state_t state_q, state_d;

  assign cls = classify(ir_op, ir_shamt, ir_funct);

  always_comb begin
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = (cls == CL_NONE) ? ST_FETCH : ST_EXEC;
      ST_EXEC: begin
        case (cls)
          CL_RTYPE:           state_d = ST_RWB;
          CL_LOAD, CL_STORE:  state_d = ST_MEM;
          default:            state_d = ST_FETCH;
        endcase
      end
      ST_MEM:    state_d = (cls == CL_LOAD) ? ST_LWB : ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign state        = state_q;
  assign aluop        = (state_q == ST_EXEC) ? class_aluop(cls) : AOP_ADD;
  assign fetch_fire   = (state_q == ST_FETCH);
  assign decode_fire  = (state_q == ST_DECODE);
  assign exec_load    = (state_q == ST_EXEC) && (cls != CL_BRANCH);
  assign branch_taken = (state_q == ST_EXEC) && (cls == CL_BRANCH) && alu_zero;
  assign store_fire   = (state_q == ST_MEM) && (cls == CL_STORE);
  assign mdr_load     = (state_q == ST_MEM) && (cls == CL_LOAD);
  assign reg_write    = (state_q == ST_RWB) || (state_q == ST_LWB);
  assign dst_is_rd    = (state_q == ST_RWB);
  assign src_is_mem   = (state_q == ST_LWB);

  p_fetch_to_decode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FETCH |=> state_q == ST_DECODE);
  p_load_to_lwb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEM && cls == CL_LOAD) |=> state_q == ST_LWB);
  p_wb_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RWB || state_q == ST_LWB) |=> state_q == ST_FETCH);
  p_bad_encoding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE && cls == CL_NONE) |=> state_q == ST_FETCH);
endmodule

// File: rtl/mcyc_cpu.sv
module mcyc_cpu
  import mcyc_pkg::*;
#(
  parameter int PCW = WORD_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [PCW-1:0]    mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we
);
  localparam int BYTE_SH = WORD_W - PCW;

  logic [PCW-1:0] pc_q;
  word_t ir_q, a_q, b_q, aluout_q, mdr_q;

  state_t  state;
  iclass_t cls;
  aluop_t  aluop;
  logic fetch_fire, decode_fire, exec_load, branch_taken, store_fire;
  logic mdr_load, reg_write, dst_is_rd, src_is_mem;

  logic [5:0]       f_op, f_fn;
  logic [FLD_W-1:0] f_rs, f_rt, f_rd, f_sh;
  logic [IMM_W-1:0] f_imm;
  assign f_op  = ir_q[31:26];
  assign f_rs  = ir_q[25:21];
  assign f_rt  = ir_q[20:16];
  assign f_rd  = ir_q[15:11];
  assign f_sh  = ir_q[10:6];
  assign f_fn  = ir_q[5:0];
  assign f_imm = ir_q[15:0];

  word_t rf_a, rf_b, rf_wd, alu_b, alu_res, br_target;
  logic [3:0] alu_code;
  logic alu_zero;
  logic [FLD_W-1:0] rf_wa;

  mcyc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ir_op(f_op), .ir_shamt(f_sh), .ir_funct(f_fn), .alu_zero(alu_zero),
    .state(state), .cls(cls), .aluop(aluop),
    .fetch_fire(fetch_fire), .decode_fire(decode_fire), .exec_load(exec_load),
    .branch_taken(branch_taken), .store_fire(store_fire), .mdr_load(mdr_load),
    .reg_write(reg_write), .dst_is_rd(dst_is_rd), .src_is_mem(src_is_mem)
  );

  assign rf_wa = dst_is_rd ? f_rd : f_rt;
  assign rf_wd = src_is_mem ? mdr_q : aluout_q;

  mcyc_regfile #(.N_ENT(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(f_rs), .ra_b(f_rt), .rd_a(rf_a), .rd_b(rf_b),
    .we(reg_write), .wa(rf_wa), .wd(rf_wd)
  );

  assign alu_b = (cls == CL_LOAD || cls == CL_STORE) ? sext_imm(f_imm) : b_q;

  mcyc_alu u_alu (
    .aluop(aluop), .funct(f_fn), .opa(a_q), .opb(alu_b),
    .code(alu_code), .result(alu_res), .zero(alu_zero)
  );

  // Branch target in byte units: incremented PC plus offset scaled to words
  assign br_target = {pc_q, {BYTE_SH{1'b0}}} + (sext_imm(f_imm) << BYTE_SH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
      mdr_q    <= '0;
    end else begin
      if (fetch_fire) begin
        ir_q <= mem_rdata;
        pc_q <= pc_q + PCW'(1);
      end
      if (decode_fire) begin
        a_q      <= rf_a;
        b_q      <= rf_b;
        aluout_q <= br_target;
      end
      if (exec_load)    aluout_q <= alu_res;
      if (branch_taken) pc_q     <= aluout_q[WORD_W-1:BYTE_SH];
      if (mdr_load)     mdr_q    <= mem_rdata;
    end
  end

  assign mem_addr  = (state == ST_MEM) ? aluout_q[WORD_W-1:BYTE_SH] : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = store_fire;

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fire |=> pc_q == $past(pc_q) + PCW'(1));
  p_branch_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    branch_taken |=> pc_q == $past(aluout_q[WORD_W-1:BYTE_SH]));
  p_store_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_fetch_decode_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    decode_fire |=> b_q == $past(rf_b));
endmodule

// File: tb/tb_mcyc_cpu.sv
module tb_mcyc_cpu;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW = 256;

  localparam logic [5:0] T_LD = 6'b100011, T_ST = 6'b101011, T_BR = 6'b000100;
  localparam logic [5:0] T_ADD = 6'b100000, T_SUB = 6'b100010, T_AND = 6'b100100;
  localparam logic [5:0] T_OR = 6'b100101, T_SLT = 6'b101010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] mem_rdata, mem_wdata;
  logic [29:0] mem_addr;
  logic mem_we;
  logic [31:0] mem [MEMW];
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  mcyc_cpu dut (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  function automatic logic [31:0] rop(input int rs, rt, rd, sh, input logic [5:0] fn);
    return {6'b0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] iop(input logic [5:0] op, input int rs, rt, off);
    return {op, 5'(rs), 5'(rt), 16'(off)};
  endfunction
  function automatic logic [31:0] halt();
    return iop(T_BR, 0, 0, -1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wipe();
    for (int i = 0; i < MEMW; i++) mem[i] = 32'h0;
  endtask

  // Reset, run for ncyc cycles, report first store cycle and number of store cycles
  task automatic run(input int ncyc, output int first_we, output int we_cnt);
    first_we = -1;
    we_cnt = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", 32'(mem_addr), 32'h0);
    chk("R1 we in reset", 32'(mem_we), 32'h0);
    rst_n = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      if (c == 0) chk("R1 first fetch addr", 32'(mem_addr), 32'h0);
      if (c == 1) chk("R2 next word addr", 32'(mem_addr), 32'h1);
      if (mem_we) begin
        we_cnt++;
        if (first_we < 0) first_we = c;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_arith();
    int fw, wc;
    wipe();
    mem[64] = 32'd7;
    mem[65] = 32'hFFFF_FFFB;
    mem[0]  = iop(T_LD, 0, 1, 256);
    mem[1]  = iop(T_LD, 0, 2, 260);
    mem[2]  = rop(1, 2, 3, 0, T_ADD);
    mem[3]  = rop(1, 2, 4, 0, T_SUB);
    mem[4]  = rop(1, 2, 5, 0, T_AND);
    mem[5]  = rop(1, 2, 6, 0, T_OR);
    mem[6]  = rop(2, 1, 7, 0, T_SLT);
    mem[7]  = rop(1, 2, 8, 0, T_SLT);
    for (int k = 0; k < 6; k++) mem[8+k] = iop(T_ST, 0, 3+k, 512 + 4*k);
    mem[14] = halt();
    run(150, fw, wc);
    chk("R4 add 7+-5", mem[128], 32'd2);
    chk("R4 sub 7--5", mem[129], 32'd12);
    chk("R5 and", mem[130], 32'd3);
    chk("R5 or", mem[131], 32'hFFFF_FFFF);
    chk("R6 slt -5<7", mem[132], 32'd1);
    chk("R6 slt 7<-5", mem[133], 32'd0);
    chk("R11 first store cycle", 32'(fw), 32'd37);
    chk("R8 store strobe count", 32'(wc), 32'd6);
  endtask

  task automatic t_ldst();
    int fw, wc;
    wipe();
    mem[64]  = 32'd408;
    mem[100] = 32'h1234_5678;
    mem[0] = iop(T_LD, 0, 1, 256);
    mem[1] = iop(T_LD, 1, 2, -8);
    mem[2] = iop(T_ST, 1, 2, 100);
    mem[3] = iop(T_ST, 1, 1, -4);
    mem[4] = halt();
    run(80, fw, wc);
    chk("R7 load neg offset then store", mem[127], 32'h1234_5678);
    chk("R8 store neg offset", mem[101], 32'd408);
    chk("R8 source untouched", mem[100], 32'h1234_5678);
    chk("R8 store strobe count", 32'(wc), 32'd2);
    chk("R11 load cycles", 32'(fw), 32'd13);
  endtask

  task automatic t_branch();
    int fw, wc;
    wipe();
    mem[64] = 32'd5;
    mem[65] = 32'd5;
    mem[128] = 32'hDEAD_0000;
    mem[129] = 32'hDEAD_0001;
    mem[0]  = iop(T_LD, 0, 1, 256);
    mem[1]  = iop(T_LD, 0, 2, 260);
    mem[2]  = iop(T_BR, 1, 2, 2);
    mem[3]  = iop(T_ST, 0, 1, 512);
    mem[4]  = iop(T_ST, 0, 1, 516);
    mem[5]  = iop(T_BR, 1, 0, 1);
    mem[6]  = iop(T_ST, 0, 2, 520);
    mem[7]  = rop(3, 1, 3, 0, T_ADD);
    mem[8]  = iop(T_BR, 3, 1, -2);
    mem[9]  = iop(T_ST, 0, 3, 524);
    mem[10] = halt();
    run(120, fw, wc);
    chk("R9 taken skips store", mem[128], 32'hDEAD_0000);
    chk("R9 taken skips store 2", mem[129], 32'hDEAD_0001);
    chk("R9 not taken falls through", mem[130], 32'd5);
    chk("R9 backward loop twice", mem[131], 32'd10);
    chk("R11 branch cycles", 32'(fw), 32'd19);
    chk("R8 store strobe count", 32'(wc), 32'd2);
  endtask

  task automatic t_zero_and_bad();
    int fw, wc;
    wipe();
    mem[64] = 32'hAAAA_5555;
    mem[128] = 32'hFFFF_FFFF;
    mem[129] = 32'hFFFF_FFFF;
    mem[131] = 32'h5A5A_5A5A;
    mem[132] = 32'h5A5A_5A5A;
    mem[0]  = iop(T_LD, 0, 0, 256);
    mem[1]  = iop(T_ST, 0, 0, 512);
    mem[2]  = iop(T_LD, 0, 1, 256);
    mem[3]  = rop(1, 1, 0, 0, T_ADD);
    mem[4]  = iop(T_ST, 0, 0, 516);
    mem[5]  = rop(0, 1, 2, 0, T_ADD);
    mem[6]  = iop(T_ST, 0, 2, 520);
    mem[7]  = rop(1, 1, 5, 3, T_ADD);
    mem[8]  = rop(1, 1, 6, 0, 6'b000001);
    mem[9]  = 32'hFC00_0000;
    mem[10] = iop(T_ST, 0, 5, 524);
    mem[11] = iop(T_ST, 0, 6, 528);
    mem[12] = halt();
    run(150, fw, wc);
    chk("R10 load to r0 ignored", mem[128], 32'h0);
    chk("R10 add to r0 ignored", mem[129], 32'h0);
    chk("R10 r0 reads zero as operand", mem[130], 32'hAAAA_5555);
    chk("R12 nonzero shift field ignored", mem[131], 32'h0);
    chk("R12 unknown function ignored", mem[132], 32'h0);
    chk("R12 unknown opcode harmless", 32'(wc), 32'd5);
    chk("R11 first store after load", 32'(fw), 32'd8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_arith();
    t_ldst();
    t_branch();
    t_zero_and_bad();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule